// File: doc/BRIEF.md
# Keyed Byte Flip-and-Rotate Tag Generator

This block condenses a 32-bit data word into an 8-bit integrity tag under the control of a 16-bit secret key. The word is cut into four byte lanes. In each lane the byte may be inverted, then it is rotated left by a lane-specific amount. The four lane results are XORed into one byte, which is the tag. A sender attaches the tag to outgoing data. A receiver recomputes the tag over the received data with the same key and compares the two values.

Data enters through a valid/ready handshake. After reset the block is always ready. The key is held in an internal register that changes only when the load strobe is pulsed. With the default single pipeline stage, the tag and its valid flag come out of registers one clock after the word is accepted. A parameter can remove that stage so the tag is produced combinationally in the acceptance cycle.

Top module: `byte_tag_gen`

## Requirements
- R1: While `rst` is high, the next clock edge drives `tag_valid` to 0, `in_ready` to 0 and `tag_out` to 0.
- R2: After `rst` has been low at a clock edge, `in_ready` is 1 from the following cycle onward.
- R3: Byte lane i is bits [8i+7:8i] of `in_data`. When key bit 12+i is 1, that byte is bitwise inverted before it is rotated; when the bit is 0 the byte passes through unchanged.
- R4: The rotate amount for lane i is key bits [3i+2:3i], a value from 0 to 7. Lane i is rotated left by that many positions, and bits leaving bit 7 re-enter at bit 0. An amount of 0 leaves the byte unchanged.
- R5: `tag_out` is the bitwise XOR of the four flipped and rotated lane bytes.
- R6: In an accepted cycle (`in_valid` and `in_ready` both high), `tag_valid` is 1 in the next cycle, and it is 0 after any cycle with no acceptance.
- R7: The key register takes the value of `key_in` only at an edge where `key_load` is 1. A word accepted in the same cycle as a load uses the key that was stored before that load.
- R8: A key load in the cycle after an acceptance does not change the tag reported for that accepted word.
- R9: When no word is accepted, `tag_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word present |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Word to tag, four byte lanes |
| key_load | input | 1 | Strobe that writes key_in into the key register |
| key_in | input | 16 | New key value |
| tag_valid | output | 1 | Tag output is valid |
| tag_out | output | 8 | Computed tag |

## Verification
The bench covers the following corner cases, and each one catches a specific kind of wrong design:
- All-zero keys, which should leave every byte unchanged. A design that inverts or rotates anyway produces a wrong tag.
- A single flip bit on its own. A design that swaps flip-bit positions inverts the wrong lane.
- A rotate amount of 1 applied to a byte with both end bits set. A design that shifts instead of rotating, or rotates the wrong way, drops or misplaces the wrap-around bit.
- A key load in the same cycle as an acceptance. A design that bypasses the new key into that word shows a different tag.
- A key load in the cycle after an acceptance. A design that recomputes the tag at the output corrupts the in-flight result.
- Idle gaps. A design that lets `tag_out` drift when no word is accepted fails here.

// File: rtl/tagk_pkg.sv
package tagk_pkg;

  // bit index of the inversion control for lane i
  function automatic int unsigned flip_bit(int unsigned lanes, int unsigned rot_w, int unsigned i);
    return lanes * rot_w + i;
  endfunction

  // low bit index of the rotate field for lane i
  function automatic int unsigned rot_lsb(int unsigned rot_w, int unsigned i);
    return rot_w * i;
  endfunction

endpackage

// File: rtl/tagk_key_reg.sv
module tagk_key_reg #(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] din,
  output logic [KEY_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VAL;
    else if (load) q <= din;
  end

  a_r7_key_loads: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));

  a_r7_key_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !$past(rst)) |=> $stable(q));

endmodule

// File: rtl/tagk_lane.sv
module tagk_lane #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned ROT_W = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flip,
  input  logic [ROT_W-1:0]  rot,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);

  logic [LANE_W-1:0]   flipped;
  logic [2*LANE_W-1:0] doubled;

  always_comb begin
    flipped = flip ? ~din : din;
    doubled = {flipped, flipped} << rot;
    dout    = doubled[2*LANE_W-1:LANE_W];
  end

  // R3/R4: inversion changes the bit count, rotation never does
  a_r4_bits_conserved: assert property (@(posedge clk) disable iff (rst)
    $countones(dout) == (flip ? (LANE_W - $countones(din)) : $countones(din)));

  a_r4_zero_rot_identity: assert property (@(posedge clk) disable iff (rst)
    (rot == '0 && !flip) |-> (dout == din));

endmodule

// File: rtl/tagk_fold.sv
module tagk_fold #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] lanes,
  output logic [LANE_W-1:0]       folded
);

  always_comb begin
    folded = '0;
    for (int i = 0; i < LANES; i++) begin
      folded = folded ^ lanes[i*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/byte_tag_gen.sv
module byte_tag_gen
  import tagk_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter bit          PIPE   = 1'b1,
  localparam int unsigned ROT_W  = $clog2(LANE_W),
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned KEY_W  = LANES * (ROT_W + 1),
  parameter logic [KEY_W-1:0] KEY_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              key_load,
  input  logic [KEY_W-1:0]  key_in,
  output logic              tag_valid,
  output logic [LANE_W-1:0] tag_out
);

  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] lane_out;
  logic [LANE_W-1:0] comb_tag;
  logic              ready_q;
  logic              accept;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  tagk_key_reg #(.KEY_W(KEY_W), .RESET_VAL(KEY_RESET)) u_key (
    .clk (clk),
    .rst (rst),
    .load(key_load),
    .din (key_in),
    .q   (key_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tagk_lane #(.LANE_W(LANE_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .flip(key_q[flip_bit(LANES, ROT_W, i)]),
      .rot (key_q[rot_lsb(ROT_W, i) +: ROT_W]),
      .din (in_data[i*LANE_W +: LANE_W]),
      .dout(lane_out[i*LANE_W +: LANE_W])
    );
  end

  tagk_fold #(.LANES(LANES), .LANE_W(LANE_W)) u_fold (
    .lanes (lane_out),
    .folded(comb_tag)
  );

  if (PIPE) begin : g_pipe
    logic              valid_q;
    logic [LANE_W-1:0] tag_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else begin
        valid_q <= accept;
        if (accept) tag_q <= comb_tag;
      end
    end

    assign tag_valid = valid_q;
    assign tag_out   = tag_q;

    a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
      accept |=> tag_valid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
      !accept |=> !tag_valid);

    a_r9_tag_held_when_idle: assert property (@(posedge clk) disable iff (rst)
      (!accept && !$past(rst)) |=> $stable(tag_out));

    a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!tag_valid && !in_ready && tag_out == '0));
  end else begin : g_comb
    assign tag_valid = accept;
    assign tag_out   = comb_tag;
  end

  a_r2_ready_after_reset: assert property (@(posedge clk)
    !rst |=> in_ready);

endmodule

// File: tb/byte_tag_gen_bench.sv
`timescale 1ns/1ps
module byte_tag_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        key_load = 1'b0;
  logic [15:0] key_in = '0;
  logic        tag_valid;
  logic [7:0]  tag_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  logic       m_valid = 1'b0;
  logic [7:0] m_tag = '0;
  logic [15:0] m_key = '0;
  logic       m_ready = 1'b0;

  always #2 clk = ~clk;

  byte_tag_gen u_byte_tag_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .key_load(key_load), .key_in(key_in),
    .tag_valid(tag_valid), .tag_out(tag_out)
  );

  function automatic logic [7:0] ref_tag(logic [31:0] d, logic [15:0] k);
    logic [7:0] acc = 8'h00;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = d[8*i +: 8];
      int amt = int'(k[3*i +: 3]);
      if (k[12+i]) b = ~b;
      for (int s = 0; s < amt; s++) b = {b[6:0], b[7]};
      acc = acc ^ b;
    end
    return acc;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 1'b0; m_tag = '0; m_key = '0; m_ready = 1'b0;
    end else begin
      m_valid = in_valid && m_ready;
      if (m_valid) m_tag = ref_tag(in_data, m_key);
      if (key_load) m_key = key_in;
      m_ready = 1'b1;
    end
  end

  task automatic compare();
    checks++;
    if (tag_valid !== m_valid || tag_out !== m_tag || in_ready !== m_ready) begin
      failures++;
      $display("FAIL %s: valid=%0b tag=%02h ready=%0b expected valid=%0b tag=%02h ready=%0b",
               req, tag_valid, tag_out, in_ready, m_valid, m_tag, m_ready);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d, input logic kl, input logic [15:0] k);
    @(negedge clk);
    compare();
    in_valid = v; in_data = d; key_load = kl; key_in = k;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    req = "R1";
    repeat (3) step(1'b1, 32'hFFFF_FFFF, 1'b0, '0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    req = "R2"; step(1'b0, '0, 1'b0, '0);
    // R5: zero key, distinct lane bits -> 0x0F
    req = "R5"; step(1'b1, 32'h0102_0408, 1'b0, '0);
    step(1'b0, '0, 1'b0, '0);
    // R9: idle, tag holds
    req = "R9"; step(1'b0, '0, 1'b0, '0); step(1'b0, 32'h1234_5678, 1'b0, '0);
    // R3: flip only lane 0
    req = "R3"; step(1'b0, '0, 1'b1, 16'h1000);
    step(1'b1, 32'h0000_0000, 1'b0, '0);
    step(1'b0, '0, 1'b1, 16'h4000);
    step(1'b1, 32'h0000_0000, 1'b0, '0);
    // R4: rotate lane 0 by 1 with wrap bits
    req = "R4"; step(1'b0, '0, 1'b1, 16'h0001);
    step(1'b1, 32'h0000_0081, 1'b0, '0);
    step(1'b0, '0, 1'b1, 16'h0007);
    step(1'b1, 32'h0000_0081, 1'b0, '0);
    step(1'b0, '0, 1'b1, 16'h0E00);
    step(1'b1, 32'h8100_0000, 1'b0, '0);
    // R7: load in same cycle as accept uses old key
    req = "R7"; step(1'b1, 32'h434F_4D50, 1'b1, 16'hF249);
    step(1'b1, 32'h434F_4D50, 1'b0, '0);
    // R8: load right after accept
    req = "R8"; step(1'b1, 32'hDEAD_BEEF, 1'b0, '0);
    step(1'b0, '0, 1'b1, 16'h0000);
    step(1'b0, '0, 1'b0, '0);
    // R6: back-to-back and random traffic
    req = "R6";
    for (int n = 0; n < 400; n++) begin
      step(($urandom % 2) == 0, $urandom, ($urandom % 4) == 0, 16'($urandom));
    end
    step(1'b0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b0, '0);
    finish_run();
  end

endmodule